// File: doc/BRIEF.md
# PCI Configuration Target with Memory Window Decode

This block is the configuration-space target for one function of a multi-function PCI device that hosts a USB host controller. It recognises configuration requests addressed to its function and returns the identification words. It also holds a Command register and a single 32-bit memory Base Address Register (BAR). Software may read or write any subset of the four bytes of an aligned dword.

From the BAR and the memory-space enable in the Command register, the block produces a memory-hit flag for a 4 KB operational register window. The flag is asserted only after software has programmed the BAR and turned on memory decoding. The request port is a simplified single-cycle strobe. It is not a full bus protocol engine.

Top module: `pci_cfg_bar_target`

## Requirements
- R1: A configuration request is accepted only when `cfg_idsel` is 1, `cfg_addr[1:0]` is 00 and `cfg_addr[10:8]` equals parameter `FUNC_NUM` (default 2). An accepted request raises `cfg_ack` for one cycle, in the cycle after the request. A request that is not accepted gives no acknowledge and changes no register.
- R2: The dword at index 0 (`cfg_addr[7:2]`=0) reads 32'hA0F8_0E11, with the device ID in the upper half and the vendor ID in the lower half. Writes to this dword are ignored.
- R3: The dword at index 1 holds the Command register in bits [15:0] and reads 0 in bits [31:16]. Only Command bits 0, 1, 2, 6 and 8 are writable (mask 16'h0147). Every other bit, including bit 4, always reads 0.
- R4: On a write, byte lane n (bits [8n+7:8n]) is updated only when `cfg_be[n]` is 1. The other lanes keep their value.
- R5: The BAR is the dword at index 4. Bits [31:12] are writable and bits [11:0] always read 0, so writing all ones reads back 32'hFFFF_F000.
- R6: `mem_hit` is 1 only while Command bit 1 is set, a BAR byte covering bits [31:12] has been written since reset, and `mem_addr[31:12]` equals BAR[31:12]. The decode is combinational.
- R7: Reads of any other index return 0, and writes to those indices have no effect.
- R8: After reset the Command register and the BAR are 0, `cfg_ack` is 0 and `mem_hit` is 0.
- R9: `cfg_rdata` carries the addressed dword in the acknowledge cycle of a read. In every other cycle it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_req | input | 1 | Configuration request strobe, one cycle |
| cfg_idsel | input | 1 | Device select for configuration cycles |
| cfg_we | input | 1 | 1 = write, 0 = read |
| cfg_addr | input | 11 | Function [10:8], dword index [7:2], must-be-zero [1:0] |
| cfg_be | input | 4 | Byte enables, active high |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, valid with cfg_ack |
| cfg_ack | output | 1 | Request accepted, one cycle after the request |
| mem_addr | input | 32 | Memory request address to decode |
| mem_hit | output | 1 | Address falls in the enabled 4 KB window |

## Verification
Each configuration result is registered once. The acknowledge and the read word appear in the cycle after the request strobe. A write becomes visible to any request issued in a later cycle. The bench drives a request at a falling edge and samples `cfg_ack` and `cfg_rdata` at the next falling edge, which is one rising edge later. The memory decode has no register stage, so the bench sets `mem_addr` and samples `mem_hit` a short delay later within the same cycle, after all configuration writes have settled.

// File: rtl/pci_cfg_bar_target.sv
module pci_cfg_bar_target #(
  parameter logic [2:0]  FUNC_NUM  = 3'd2,
  parameter logic [15:0] VENDOR_ID = 16'h0E11,
  parameter logic [15:0] DEVICE_ID = 16'hA0F8,
  parameter int          WIN_BITS  = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_req,
  input  logic        cfg_idsel,
  input  logic        cfg_we,
  input  logic [10:0] cfg_addr,
  input  logic [3:0]  cfg_be,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  output logic        cfg_ack,
  input  logic [31:0] mem_addr,
  output logic        mem_hit
);

  localparam int          BAR_W    = 32 - WIN_BITS;
  localparam logic [15:0] CMD_MASK = 16'h0147;
  localparam logic [5:0]  IDX_ID   = 6'd0;
  localparam logic [5:0]  IDX_CMD  = 6'd1;
  localparam logic [5:0]  IDX_BAR  = 6'd4;

  logic [15:0]      cmd_q;
  logic [BAR_W-1:0] bar_q;
  logic             bar_set;
  logic [31:0]      lane_mask, wr_masked, rd_word;
  logic [5:0]       idx;
  logic             sel;

  assign idx       = cfg_addr[7:2];
  assign sel       = cfg_req && cfg_idsel && (cfg_addr[1:0] == 2'b00) && (cfg_addr[10:8] == FUNC_NUM);
  assign lane_mask = {{8{cfg_be[3]}}, {8{cfg_be[2]}}, {8{cfg_be[1]}}, {8{cfg_be[0]}}};
  assign wr_masked = cfg_wdata & lane_mask;

  always_comb begin
    case (idx)
      IDX_ID:  rd_word = {DEVICE_ID, VENDOR_ID};
      IDX_CMD: rd_word = {16'h0000, cmd_q};
      IDX_BAR: rd_word = {bar_q, {WIN_BITS{1'b0}}};
      default: rd_word = 32'h0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q     <= '0;
      bar_q     <= '0;
      bar_set   <= 1'b0;
      cfg_ack   <= 1'b0;
      cfg_rdata <= '0;
    end else begin
      cfg_ack   <= sel;
      cfg_rdata <= (sel && !cfg_we) ? rd_word : 32'h0;
      if (sel && cfg_we) begin
        if (idx == IDX_CMD)
          cmd_q <= (cmd_q & ~lane_mask[15:0]) | (wr_masked[15:0] & CMD_MASK);
        if (idx == IDX_BAR) begin
          bar_q   <= (bar_q & ~lane_mask[31:WIN_BITS]) | wr_masked[31:WIN_BITS];
          bar_set <= bar_set | (|lane_mask[31:WIN_BITS]);
        end
      end
    end
  end

  assign mem_hit = cmd_q[1] && bar_set && (mem_addr[31:WIN_BITS] == bar_q);

  p_ack_decode_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ack |-> $past(cfg_req && cfg_idsel && cfg_addr[1:0] == 2'b00 && cfg_addr[10:8] == FUNC_NUM));

  p_id_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_ack && $past(!cfg_we && cfg_addr[7:2] == IDX_ID)) |-> cfg_rdata == {DEVICE_ID, VENDOR_ID});

  p_cmd_fixed_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_ack && $past(!cfg_we && cfg_addr[7:2] == IDX_CMD)) |-> (cfg_rdata & ~{16'h0, CMD_MASK}) == 32'h0);

  p_bar_low_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_ack && $past(!cfg_we && cfg_addr[7:2] == IDX_BAR)) |-> cfg_rdata[WIN_BITS-1:0] == '0);

  p_hit_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_hit |-> (cmd_q[1] && bar_set));

  p_rdata_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_ack |-> cfg_rdata == 32'h0);

endmodule

// File: tb/pci_cfg_bar_target_bench.sv
module pci_cfg_bar_target_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_req = 1'b0, cfg_idsel = 1'b0, cfg_we = 1'b0;
  logic [10:0] cfg_addr = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0, mem_addr = '0;
  logic [31:0] cfg_rdata;
  logic        cfg_ack, mem_hit;
  int          n_checks = 0, n_fail = 0;

  localparam logic [10:0] A_ID = 11'h200, A_CMD = 11'h204, A_BAR = 11'h210, A_UNI = 11'h208;

  always #5 clk = ~clk;

  pci_cfg_bar_target u_pci_cfg_bar_target (
    .clk(clk), .rst_n(rst_n), .cfg_req(cfg_req), .cfg_idsel(cfg_idsel), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .cfg_ack(cfg_ack), .mem_addr(mem_addr), .mem_hit(mem_hit));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input logic sel_in, input logic we, input logic [10:0] a, input logic [3:0] be,
                        input logic [31:0] wd, output logic ack, output logic [31:0] rd);
    @(negedge clk);
    cfg_req = 1'b1; cfg_idsel = sel_in; cfg_we = we; cfg_addr = a; cfg_be = be; cfg_wdata = wd;
    @(negedge clk);
    cfg_req = 1'b0; cfg_idsel = 1'b0; cfg_we = 1'b0;
    ack = cfg_ack; rd = cfg_rdata;
  endtask

  task automatic wr(input logic [10:0] a, input logic [3:0] be, input logic [31:0] wd);
    logic ack; logic [31:0] rd;
    access(1'b1, 1'b1, a, be, wd, ack, rd);
  endtask

  task automatic rd_chk(input string req, input logic [10:0] a, input logic [31:0] exp);
    logic ack; logic [31:0] rd;
    access(1'b1, 1'b0, a, 4'hF, 32'h0, ack, rd);
    check({req, " ack"}, {31'h0, ack}, 32'h1);
    check(req, rd, exp);
  endtask

  task automatic hit_chk(input string req, input logic [31:0] a, input logic exp);
    @(negedge clk);
    mem_addr = a;
    #1;
    check(req, {31'h0, mem_hit}, {31'h0, exp});
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    check("R8 ack after reset", {31'h0, cfg_ack}, 32'h0);
    check("R9 rdata idle", cfg_rdata, 32'h0);
    hit_chk("R8 no hit after reset", 32'h0000_0010, 1'b0);
    rd_chk("R8 cmd reset", A_CMD, 32'h0);
    rd_chk("R8 bar reset", A_BAR, 32'h0);
  endtask

  task automatic t_ident();
    rd_chk("R2 id read", A_ID, 32'hA0F8_0E11);
    wr(A_ID, 4'hF, 32'h1234_5678);
    rd_chk("R2 id after write", A_ID, 32'hA0F8_0E11);
  endtask

  task automatic t_command();
    wr(A_CMD, 4'hF, 32'hFFFF_FFFF);
    rd_chk("R3 cmd writable mask", A_CMD, 32'h0000_0147);
    wr(A_CMD, 4'b0001, 32'h0000_0000);
    rd_chk("R4 cmd low lane only", A_CMD, 32'h0000_0100);
    wr(A_CMD, 4'b0010, 32'h0000_0000);
    rd_chk("R4 cmd high lane only", A_CMD, 32'h0000_0000);
    wr(A_CMD, 4'b0001, 32'h0000_0010);
    rd_chk("R3 mwi bit stays zero", A_CMD, 32'h0000_0000);
  endtask

  task automatic t_decode();
    logic ack; logic [31:0] rd;
    access(1'b0, 1'b1, A_CMD, 4'hF, 32'h0000_0007, ack, rd);
    check("R1 no ack without idsel", {31'h0, ack}, 32'h0);
    access(1'b1, 1'b1, 11'h304, 4'hF, 32'h0000_0007, ack, rd);
    check("R1 no ack wrong function", {31'h0, ack}, 32'h0);
    access(1'b1, 1'b1, 11'h205, 4'hF, 32'h0000_0007, ack, rd);
    check("R1 no ack low bits set", {31'h0, ack}, 32'h0);
    rd_chk("R1 cmd untouched by rejected writes", A_CMD, 32'h0);
    wr(A_CMD, 4'hF, 32'h0);
  endtask

  task automatic t_unimpl();
    rd_chk("R7 unimplemented read", A_UNI, 32'h0);
    wr(A_UNI, 4'hF, 32'hDEAD_BEEF);
    rd_chk("R7 unimplemented after write", A_UNI, 32'h0);
    rd_chk("R7 cmd unaffected", A_CMD, 32'h0);
    rd_chk("R7 bar unaffected", A_BAR, 32'h0);
  endtask

  task automatic t_bar();
    wr(A_CMD, 4'hF, 32'h0000_0002);
    hit_chk("R6 no hit before bar written", 32'h0000_0010, 1'b0);
    wr(A_BAR, 4'hF, 32'hFFFF_FFFF);
    rd_chk("R5 size probe", A_BAR, 32'hFFFF_F000);
    wr(A_BAR, 4'hF, 32'h1234_5678);
    rd_chk("R5 bar full write", A_BAR, 32'h1234_5000);
    wr(A_BAR, 4'b0100, 32'h00AA_0000);
    rd_chk("R4 bar single lane", A_BAR, 32'h12AA_5000);
    hit_chk("R6 hit window base", 32'h12AA_5000, 1'b1);
    hit_chk("R6 hit window top", 32'h12AA_5FFC, 1'b1);
    hit_chk("R6 miss above window", 32'h12AA_6000, 1'b0);
    hit_chk("R6 miss below window", 32'h12AA_4FFC, 1'b0);
    wr(A_CMD, 4'hF, 32'h0000_0001);
    hit_chk("R6 miss when memory disabled", 32'h12AA_5100, 1'b0);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_ident();
        t_command();
        t_decode();
        t_unimpl();
        t_bar();
      end
      begin
        repeat (5000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule